// File: doc/BRIEF.md
# Frame Control Field Decoder

This block sits behind the deserializer of a serial receive path. With each received frame it takes a 4-bit control field and a parallel data field. The control code says what kind of frame arrived: control, data or fill. For a data frame it also says whether the data field was sent with its bits flipped, and it carries one extra flag bit.

The decoder turns the data field back to its original polarity. It reports the frame type on two active-low "available" outputs and flags any control code that is not legal. A mode input picks how the flag bit is read. In one setting it is a user data bit. In the other it marks the even or odd half of a word sent as two frames.

All outputs are registered. They load only on a clock edge where the frame strobe is high, so a frame's result appears one strobe cycle after it is offered. The raw control field is also registered and passed out for link error checking downstream.

Top module: `frame_ctl_decoder`

## Requirements
- R1: While reset is low, ctl_avail_n and data_avail_n are 1, and code_err, data_inv, user_flag, odd_half, data_out and ctl_echo are all 0.
- R2: Control codes 1101 (flag 0) and 1011 (flag 1) mark a data frame sent true. data_avail_n goes 0, ctl_avail_n stays 1, data_inv is 0 and data_out equals the data field.
- R3: Control codes 0010 (flag 0) and 0100 (flag 1) mark a data frame sent inverted. data_avail_n goes 0, data_inv is 1 and data_out is the bitwise complement of the data field.
- R4: Control code 0011 marks a control frame. ctl_avail_n goes 0, data_avail_n stays 1, data_inv is 0 and data_out equals the data field without inversion.
- R5: Control code 1100 marks a fill frame. Both available outputs are 1, code_err is 0 and data_out is 0.
- R6: Every other control code sets code_err to 1 for that frame. Both available outputs are then 1 and data_out is 0.
- R7: With flag_sel at 1 on a data frame, user_flag carries the decoded flag bit and odd_half is 0.
- R8: With flag_sel at 0 on a data frame, odd_half carries the decoded flag bit (1 = odd half) and user_flag is 0. On frames that are not data frames, both are 0.
- R9: Outputs load only on a rising clock edge with frame_stb at 1. They keep their values across edges where frame_stb is 0, whatever the other inputs do.
- R10: ctl_echo holds the raw control field of the last strobed frame, whatever its code.
- R11: ctl_avail_n and data_avail_n are never both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | Frame strobe; the current inputs are decoded and loaded on this edge |
| flag_sel | input | 1 | 1: flag bit is user data; 0: flag bit marks the odd half |
| ctl_field | input | 4 | Received control code |
| data_field | input | DATA_W (20) | Received data field |
| ctl_avail_n | output | 1 | Low for a control frame |
| data_avail_n | output | 1 | Low for a data frame |
| code_err | output | 1 | Illegal control code |
| data_inv | output | 1 | Data field was sent inverted |
| data_out | output | DATA_W (20) | Restored data field |
| user_flag | output | 1 | Flag bit as user data |
| odd_half | output | 1 | Flag bit as the odd-half marker |
| ctl_echo | output | 4 | Registered raw control field |

## Verification
The hardest case to produce is an output that holds its value while the inputs change. The inputs must move to a code that would give a very different result, such as an illegal code with fresh data, while the strobe stays low for several edges. The bench does this directly after loading a valid inverted data frame. It then checks that every output still shows that earlier frame. It also applies the same data field under several codes and both flag modes. This makes inversion, pass-through and blanking each show up as a distinct value on data_out.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    FK_FILL   = 3'd0,
    FK_DATA_T = 3'd1,
    FK_DATA_I = 3'd2,
    FK_CTRL   = 3'd3,
    FK_BAD    = 3'd4
  } fkind_e;

  typedef struct packed {
    fkind_e kind;
    logic   flag;
  } fdec_t;

  // Classify a control code; the flag bit is meaningful only for data kinds.
  function automatic fdec_t classify(input logic [3:0] code);
    fdec_t r;
    r.flag = 1'b0;
    case (code)
      4'b1101: r.kind = FK_DATA_T;
      4'b1011: begin r.kind = FK_DATA_T; r.flag = 1'b1; end
      4'b0010: r.kind = FK_DATA_I;
      4'b0100: begin r.kind = FK_DATA_I; r.flag = 1'b1; end
      4'b0011: r.kind = FK_CTRL;
      4'b1100: r.kind = FK_FILL;
      default: r.kind = FK_BAD;
    endcase
    return r;
  endfunction

  function automatic logic is_data(input fkind_e k);
    return (k == FK_DATA_T) || (k == FK_DATA_I);
  endfunction

endpackage

// File: rtl/fcd_code_decode.sv
module fcd_code_decode
  import fcd_pkg::*;
(
  input  logic [3:0] code,
  input  logic       flag_sel,
  output logic       is_ctrl,
  output logic       is_dat,
  output logic       is_bad,
  output logic       invert,
  output logic       pass,
  output logic       uflag,
  output logic       oflag
);
  fdec_t dec;

  always_comb begin
    dec     = classify(code);
    is_ctrl = (dec.kind == FK_CTRL);
    is_dat  = is_data(dec.kind);
    is_bad  = (dec.kind == FK_BAD);
    invert  = (dec.kind == FK_DATA_I);
    pass    = is_dat || is_ctrl;
    uflag   = is_dat && flag_sel && dec.flag;
    oflag   = is_dat && !flag_sel && dec.flag;
  end
endmodule

// File: rtl/fcd_data_restore.sv
module fcd_data_restore #(
  parameter int W = 20
) (
  input  logic [W-1:0] din,
  input  logic         invert,
  input  logic         pass,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = pass & (din[i] ^ invert);
  end
endmodule

// File: rtl/fcd_out_reg.sv
module fcd_out_reg #(
  parameter int W  = 20,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          ctrl_d,
  input  logic          dat_d,
  input  logic          bad_d,
  input  logic          inv_d,
  input  logic          uflag_d,
  input  logic          oflag_d,
  input  logic [W-1:0]  data_d,
  input  logic [CW-1:0] code_d,
  output logic          ctl_avail_n,
  output logic          data_avail_n,
  output logic          code_err,
  output logic          data_inv,
  output logic          user_flag,
  output logic          odd_half,
  output logic [W-1:0]  data_out,
  output logic [CW-1:0] ctl_echo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_avail_n  <= 1'b1;
      data_avail_n <= 1'b1;
      code_err     <= 1'b0;
      data_inv     <= 1'b0;
      user_flag    <= 1'b0;
      odd_half     <= 1'b0;
      data_out     <= '0;
      ctl_echo     <= '0;
    end else if (load) begin
      ctl_avail_n  <= !ctrl_d;
      data_avail_n <= !dat_d;
      code_err     <= bad_d;
      data_inv     <= inv_d;
      user_flag    <= uflag_d;
      odd_half     <= oflag_d;
      data_out     <= data_d;
      ctl_echo     <= code_d;
    end
  end
endmodule

// File: rtl/frame_ctl_decoder.sv
module frame_ctl_decoder #(
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              flag_sel,
  input  logic [3:0]        ctl_field,
  input  logic [DATA_W-1:0] data_field,
  output logic              ctl_avail_n,
  output logic              data_avail_n,
  output logic              code_err,
  output logic              data_inv,
  output logic [DATA_W-1:0] data_out,
  output logic              user_flag,
  output logic              odd_half,
  output logic [3:0]        ctl_echo
);
  localparam int CODE_W = 4;

  // Named internal events, visible to the bound checker.
  logic              upd_evt;
  logic              cls_ctrl, cls_data, cls_bad, cls_inv, cls_pass;
  logic              f_user, f_odd;
  logic [DATA_W-1:0] restored;

  assign upd_evt = frame_stb;

  fcd_code_decode u_dec (
    .code     (ctl_field),
    .flag_sel (flag_sel),
    .is_ctrl  (cls_ctrl),
    .is_dat   (cls_data),
    .is_bad   (cls_bad),
    .invert   (cls_inv),
    .pass     (cls_pass),
    .uflag    (f_user),
    .oflag    (f_odd)
  );

  fcd_data_restore #(.W(DATA_W)) u_rest (
    .din    (data_field),
    .invert (cls_inv),
    .pass   (cls_pass),
    .dout   (restored)
  );

  fcd_out_reg #(.W(DATA_W), .CW(CODE_W)) u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (upd_evt),
    .ctrl_d       (cls_ctrl),
    .dat_d        (cls_data),
    .bad_d        (cls_bad),
    .inv_d        (cls_inv),
    .uflag_d      (f_user),
    .oflag_d      (f_odd),
    .data_d       (restored),
    .code_d       (ctl_field),
    .ctl_avail_n  (ctl_avail_n),
    .data_avail_n (data_avail_n),
    .code_err     (code_err),
    .data_inv     (data_inv),
    .user_flag    (user_flag),
    .odd_half     (odd_half),
    .data_out     (data_out),
    .ctl_echo     (ctl_echo)
  );
endmodule

// File: rtl/frame_ctl_decoder_chk.sv
module frame_ctl_decoder_chk #(
  parameter int DATA_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_evt,
  input logic              cls_ctrl,
  input logic [3:0]        ctl_field,
  input logic [DATA_W-1:0] data_field,
  input logic              ctl_avail_n,
  input logic              data_avail_n,
  input logic              code_err,
  input logic              data_inv,
  input logic [DATA_W-1:0] data_out,
  input logic              user_flag,
  input logic              odd_half,
  input logic [3:0]        ctl_echo
);
  assert_exclusive_avail_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ctl_avail_n && !data_avail_n));

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> (ctl_avail_n && data_avail_n && data_out == '0));

  assert_inv_is_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_inv |-> !data_avail_n);

  assert_ctrl_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && cls_ctrl) |=> (!data_inv && data_out == $past(data_field)));

  assert_flag_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(user_flag && odd_half));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable({ctl_avail_n, data_avail_n, code_err, data_inv,
                          data_out, user_flag, odd_half, ctl_echo}));

  assert_echo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (ctl_echo == $past(ctl_field)));
endmodule

bind frame_ctl_decoder frame_ctl_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .upd_evt      (upd_evt),
  .cls_ctrl     (cls_ctrl),
  .ctl_field    (ctl_field),
  .data_field   (data_field),
  .ctl_avail_n  (ctl_avail_n),
  .data_avail_n (data_avail_n),
  .code_err     (code_err),
  .data_inv     (data_inv),
  .data_out     (data_out),
  .user_flag    (user_flag),
  .odd_half     (odd_half),
  .ctl_echo     (ctl_echo)
);

// File: tb/tb_frame_ctl_decoder.sv
module tb_frame_ctl_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int W = 20;
  localparam int NV = 14;
  // Vector: {code[3:0], data[19:0], fsel, kind[1:0] (0 fill,1 data,2 ctrl,3 bad), inv, flag}
  localparam int VW = 4 + W + 1 + 2 + 1 + 1;
  localparam logic [NV-1:0][VW-1:0] VEC = {
    {4'b1101, 20'hA5C3F, 1'b1, 2'd1, 1'b0, 1'b0},
    {4'b1011, 20'hA5C3F, 1'b1, 2'd1, 1'b0, 1'b1},
    {4'b1011, 20'h12345, 1'b0, 2'd1, 1'b0, 1'b1},
    {4'b0010, 20'hA5C3F, 1'b1, 2'd1, 1'b1, 1'b0},
    {4'b0100, 20'hA5C3F, 1'b1, 2'd1, 1'b1, 1'b1},
    {4'b0100, 20'h00000, 1'b0, 2'd1, 1'b1, 1'b1},
    {4'b0011, 20'hA5C3F, 1'b1, 2'd2, 1'b0, 1'b0},
    {4'b0011, 20'hFFFFF, 1'b0, 2'd2, 1'b0, 1'b0},
    {4'b1100, 20'hA5C3F, 1'b1, 2'd0, 1'b0, 1'b0},
    {4'b0000, 20'hA5C3F, 1'b1, 2'd3, 1'b0, 1'b0},
    {4'b1111, 20'h5A5A5, 1'b0, 2'd3, 1'b0, 1'b0},
    {4'b0101, 20'h0F0F0, 1'b1, 2'd3, 1'b0, 1'b0},
    {4'b1101, 20'h0F0F0, 1'b0, 2'd1, 1'b0, 1'b0},
    {4'b1110, 20'h33333, 1'b1, 2'd3, 1'b0, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_stb = 1'b0;
  logic         flag_sel = 1'b0;
  logic [3:0]   ctl_field = '0;
  logic [W-1:0] data_field = '0;
  logic         ctl_avail_n, data_avail_n, code_err, data_inv, user_flag, odd_half;
  logic [W-1:0] data_out;
  logic [3:0]   ctl_echo;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_ctl_decoder #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .flag_sel(flag_sel),
    .ctl_field(ctl_field), .data_field(data_field),
    .ctl_avail_n(ctl_avail_n), .data_avail_n(data_avail_n), .code_err(code_err),
    .data_inv(data_inv), .data_out(data_out), .user_flag(user_flag),
    .odd_half(odd_half), .ctl_echo(ctl_echo)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] c, input logic [W-1:0] d, input logic fs);
    @(negedge clk);
    ctl_field = c; data_field = d; flag_sel = fs; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    #1;
  endtask

  // Outputs packed: {ctl_n, dat_n, err, inv, uflag, odd, data, echo}
  function automatic logic [63:0] pack_out();
    return {34'd0, ctl_avail_n, data_avail_n, code_err, data_inv, user_flag, odd_half, data_out, ctl_echo};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", pack_out(), {34'd0, 6'b110000, {W{1'b0}}, 4'h0});
    rst_n = 1'b1;

    for (int i = NV - 1; i >= 0; i--) begin
      logic [3:0]   c;
      logic [W-1:0] d;
      logic         fs, inv, fl;
      logic [1:0]   k;
      logic [W-1:0] ed;
      string        rq;
      {c, d, fs, k, inv, fl} = VEC[i];
      strobe(c, d, fs);
      ed = (k == 2'd1) ? (inv ? ~d : d) : (k == 2'd2 ? d : '0);
      rq = (k == 2'd0) ? "R5" : (k == 2'd2) ? "R4" : (k == 2'd3) ? "R6" : (inv ? "R3" : "R2");
      check(rq, {63'd0, ctl_avail_n}, {63'd0, k != 2'd2});
      check(rq, {63'd0, data_avail_n}, {63'd0, k != 2'd1});
      check("R11", {62'd0, ctl_avail_n, data_avail_n} == 0 ? 64'd1 : 64'd0, 64'd0);
      check("R6", {63'd0, code_err}, {63'd0, k == 2'd3});
      check(rq, {63'd0, data_inv}, {63'd0, inv});
      check(rq, {44'd0, data_out}, {44'd0, ed});
      check("R7", {63'd0, user_flag}, {63'd0, k == 2'd1 && fs && fl});
      check("R8", {63'd0, odd_half}, {63'd0, k == 2'd1 && !fs && fl});
      check("R10", {60'd0, ctl_echo}, {60'd0, c});
    end

    // R9: load an inverted data frame, then change inputs with strobe low.
    strobe(4'b0100, 20'h13579, 1'b0);
    held = pack_out();
    check("R3", {44'd0, data_out}, {44'd0, ~20'h13579});
    @(negedge clk);
    ctl_field = 4'b1111; data_field = 20'hFFFFF; flag_sel = 1'b1;
    repeat (4) @(negedge clk);
    ctl_field = 4'b0011; data_field = 20'h00001;
    repeat (3) @(negedge clk);
    #1;
    check("R9", pack_out(), held);

    // R1: reset in mid-run clears loaded outputs.
    strobe(4'b0011, 20'hABCDE, 1'b1);
    check("R4", {62'd0, ctl_avail_n, data_avail_n}, 64'd1);
    rst_n = 1'b0;
    #2;
    check("R1", pack_out(), {34'd0, 6'b110000, {W{1'b0}}, 4'h0});
    @(negedge clk);
    rst_n = 1'b1;
    // R8 back-to-back halves after reset
    strobe(4'b1101, 20'h00055, 1'b0);
    check("R8", {62'd0, user_flag, odd_half}, 64'd0);
    strobe(4'b1011, 20'h000AA, 1'b0);
    check("R8", {62'd0, user_flag, odd_half}, 64'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule